// File: doc/BRIEF.md
# Synthesizer Serial Control Word Port

This block is the receiving side of a serial control link for a direct digital synthesis core. A host shifts 16-bit words into it on a three-wire serial bus: an active-low select, a serial clock and a data line, most significant bit first. The block samples the three bus lines in the system clock domain and captures a word on each falling serial-clock edge while select is low. A complete word is accepted when select returns high.

Every accepted word carries its destination in its top bits. The block decodes this field and updates one of five registers: a 14-bit control word, two 28-bit frequency words or two 12-bit phase words. The register contents feed the synthesis datapath directly. A 28-bit frequency value is 14 bits wider than one word can carry. In two-write mode it is built from two consecutive words to the same frequency destination, low half first. In single-write mode one control bit chooses which half a single word replaces.

The frame FSM has states `FR_IDLE`, `FR_SHIFT`, `FR_FULL` and `FR_SKIP`. Its transitions are: select low (`FR_IDLE`→`FR_SHIFT`); 16th bit sampled (`FR_SHIFT`→`FR_FULL`); 17th bit sampled (`FR_FULL`→`FR_SKIP`); select high, accepting the word (`FR_FULL`→`FR_IDLE`); select high, discarding the frame (`FR_SHIFT`/`FR_SKIP`→`FR_IDLE`). The load FSM has states `LD_LOW` and `LD_HIGH`. Its transitions are: first half captured (`LD_LOW`→`LD_HIGH`); second half to the same destination, committing the pair (`LD_HIGH`→`LD_LOW`); any other destination (`LD_HIGH`→`LD_LOW`, or back to `LD_HIGH` when a new low half is captured for the other frequency register).

Top module: `synth_word_port`

## Requirements
- R1: After reset the control output reads 0x2100 (bit 13 two-write mode and bit 8 core reset set). All frequency and phase outputs read zero.
- R2: A frame of exactly 16 sampled bits is taken MSB first and applied when select rises. A frame with fewer than 16 bits changes no output.
- R3: A frame with more than 16 bits changes no output.
- R4: A word with bits 15:14 = 00 replaces the control output with its bits 13:0. Bit 13 of the control output is two-write mode and bit 12 is the half select.
- R5: A word with bits 15:13 = 110 loads phase 0 and 111 loads phase 1 from bits 11:0. Bit 12 of such a word is ignored.
- R6: With two-write mode set, a word with bits 15:14 = 01 (frequency 0) or 10 (frequency 1) is taken as the low half (bits 13:0). The frequency output does not change until a second word to the same destination supplies bits 27:14. Both halves are then applied together.
- R7: A word to any other destination between the two halves abandons the pending low half. A word to the other frequency register starts a new pair there.
- R8: With two-write mode clear, a frequency word replaces only bits 27:14 when half select is 1, or only bits 13:0 when it is 0. The other half is kept.
- R9: Serial-clock edges while select is high capture nothing and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data sampled on its falling edge |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_dat | input | 1 | Serial data, MSB first |
| ctl_word | output | 14 | Control word |
| freq0_word | output | 28 | Frequency word 0 |
| freq1_word | output | 28 | Frequency word 1 |
| phase0_word | output | 12 | Phase word 0 |
| phase1_word | output | 12 | Phase word 1 |

## Verification
The bench checks the frequency output between the two halves of a pair. A design that applied the low half early would show a mixed value there. It sends a phase word between the halves and expects the next frequency word to count as a new low half; a design that kept the stale pointer would commit a wrong pair. It sends frames of 10 and 18 bits and toggles the serial clock with select high; a design that counted loosely would corrupt a register. It writes single halves with each half-select value, where a design would otherwise overwrite the wrong half, and sets bit 12 in phase words, where a design would otherwise decode phase 1 or leak that bit into the value.

// File: rtl/synth_word_pkg.sv
package synth_word_pkg;
    localparam int WORD_W  = 16;
    localparam int FREQ_W  = 28;
    localparam int PHASE_W = 12;
    localparam int HALF_W  = FREQ_W / 2;
    localparam int CTL_W   = WORD_W - 2;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    // control bit positions that the load logic decodes
    localparam int CTL_TWO_WRITE = 13;
    localparam int CTL_HALF_SEL  = 12;
    localparam logic [CTL_W-1:0] CTL_RESET_VAL = 14'h2100;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_FULL,
        FR_SKIP
    } frame_state_t;

    typedef enum logic {
        LD_LOW,
        LD_HIGH
    } load_state_t;
endpackage

// File: rtl/synth_word_sync.sv
module synth_word_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_sel_n,
    input  logic ser_dat,
    output logic clk_fall,
    output logic sel_act,
    output logic dat_s
);
    // index 0: serial clock, 1: select, 2: data
    logic [2:0] chain [STAGES];
    logic       clk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 3'b011;
                    else        chain[g] <= {ser_dat, ser_sel_n, ser_clk};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 3'b011;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= chain[STAGES-1][0];
    end

    assign clk_fall = clk_prev & ~chain[STAGES-1][0];
    assign sel_act  = ~chain[STAGES-1][1];
    assign dat_s    = chain[STAGES-1][2];

    // R2: a sampling strobe never lasts two cycles
    p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fall |=> !clk_fall);
endmodule

// File: rtl/synth_word_frame.sv
module synth_word_frame
    import synth_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_fall,
    input  logic              sel_act,
    input  logic              dat_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    frame_state_t      st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE:  if (sel_act) st_d = FR_SHIFT;
            FR_SHIFT: begin
                if (!sel_act)
                    st_d = FR_IDLE;
                else if (clk_fall && cnt_q == CNT_W'(WORD_W - 1))
                    st_d = FR_FULL;
            end
            FR_FULL: begin
                if (!sel_act)     st_d = FR_IDLE;
                else if (clk_fall) st_d = FR_SKIP;
            end
            FR_SKIP:  if (!sel_act) st_d = FR_IDLE;
        endcase
    end

    // outputs and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shf_q    <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            unique case (st_q)
                FR_IDLE: cnt_q <= '0;
                FR_SHIFT: if (sel_act && clk_fall) begin
                    shf_q <= {shf_q[WORD_W-2:0], dat_s};
                    cnt_q <= cnt_q + 1'b1;
                end
                FR_FULL: if (!sel_act) begin
                    word_vld <= 1'b1;
                    word     <= shf_q;
                end
                FR_SKIP: cnt_q <= '0;
            endcase
        end
    end

    // R2, R3: a word is only released from a frame of exactly 16 bits
    p_full_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(st_q) == FR_FULL);
    p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    // R9: nothing is shifted while select is high
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_IDLE && !sel_act) |=> $stable(shf_q));
endmodule

// File: rtl/synth_word_regs.sv
module synth_word_regs
    import synth_word_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_vld,
    input  logic [WORD_W-1:0]  wr_word,
    output logic [CTL_W-1:0]   ctl_q,
    output logic [FREQ_W-1:0]  freq0_q,
    output logic [FREQ_W-1:0]  freq1_q,
    output logic [PHASE_W-1:0] phase0_q,
    output logic [PHASE_W-1:0] phase1_q
);
    load_state_t       ld_q, ld_d;
    logic [HALF_W-1:0] pend_q;
    logic              pend_sel_q;

    logic [2:0]        tag;
    logic              is_ctl, is_freq, is_phase, dst_sel;
    logic              pair_done;

    assign tag       = wr_word[WORD_W-1:WORD_W-3];
    assign is_ctl    = tag[2:1] == 2'b00;
    assign is_freq   = tag[2:1] == 2'b01 || tag[2:1] == 2'b10;
    assign is_phase  = tag[2:1] == 2'b11;
    assign dst_sel   = is_freq ? tag[2] : tag[0];
    assign pair_done = wr_vld && is_freq && ctl_q[CTL_TWO_WRITE]
                       && ld_q == LD_HIGH && pend_sel_q == dst_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= LD_LOW;
        else        ld_q <= ld_d;
    end

    always_comb begin
        ld_d = ld_q;
        unique case (ld_q)
            LD_LOW: begin
                if (wr_vld && is_freq && ctl_q[CTL_TWO_WRITE])
                    ld_d = LD_HIGH;
            end
            LD_HIGH: begin
                if (wr_vld) begin
                    if (pair_done)
                        ld_d = LD_LOW;
                    else if (is_freq && ctl_q[CTL_TWO_WRITE])
                        ld_d = LD_HIGH;
                    else
                        ld_d = LD_LOW;
                end
            end
        endcase
    end

    // register updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= CTL_RESET_VAL;
            freq0_q    <= '0;
            freq1_q    <= '0;
            phase0_q   <= '0;
            phase1_q   <= '0;
            pend_q     <= '0;
            pend_sel_q <= 1'b0;
        end else if (wr_vld) begin
            if (is_ctl) begin
                ctl_q <= wr_word[CTL_W-1:0];
            end else if (is_phase) begin
                if (dst_sel) phase1_q <= wr_word[PHASE_W-1:0];
                else         phase0_q <= wr_word[PHASE_W-1:0];
            end else if (ctl_q[CTL_TWO_WRITE]) begin
                if (pair_done) begin
                    if (dst_sel) freq1_q <= {wr_word[HALF_W-1:0], pend_q};
                    else         freq0_q <= {wr_word[HALF_W-1:0], pend_q};
                end else begin
                    pend_q     <= wr_word[HALF_W-1:0];
                    pend_sel_q <= dst_sel;
                end
            end else if (ctl_q[CTL_HALF_SEL]) begin
                if (dst_sel) freq1_q[FREQ_W-1:HALF_W] <= wr_word[HALF_W-1:0];
                else         freq0_q[FREQ_W-1:HALF_W] <= wr_word[HALF_W-1:0];
            end else begin
                if (dst_sel) freq1_q[HALF_W-1:0] <= wr_word[HALF_W-1:0];
                else         freq0_q[HALF_W-1:0] <= wr_word[HALF_W-1:0];
            end
        end
    end

    // R6: while a low half is pending, neither frequency output moves
    p_half_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q == LD_HIGH && ld_d == LD_HIGH) |=> $stable(freq0_q) && $stable(freq1_q));
    // R4: the control word only changes on an accepted word
    p_ctl_on_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> $stable(ctl_q));
    // R5: a phase word never touches a frequency output
    p_phase_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && is_phase) |=> $stable(freq0_q) && $stable(freq1_q));
    // R7: a non-frequency word always leaves the pointer at the low half
    p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !is_freq) |=> ld_q == LD_LOW);
endmodule

// File: rtl/synth_word_port.sv
module synth_word_port
    import synth_word_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_sel_n,
    input  logic               ser_dat,
    output logic [CTL_W-1:0]   ctl_word,
    output logic [FREQ_W-1:0]  freq0_word,
    output logic [FREQ_W-1:0]  freq1_word,
    output logic [PHASE_W-1:0] phase0_word,
    output logic [PHASE_W-1:0] phase1_word
);
    logic              clk_fall, sel_act, dat_s;
    logic              word_vld;
    logic [WORD_W-1:0] word;

    synth_word_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_sel_n (ser_sel_n),
        .ser_dat   (ser_dat),
        .clk_fall  (clk_fall),
        .sel_act   (sel_act),
        .dat_s     (dat_s)
    );

    synth_word_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_fall (clk_fall),
        .sel_act  (sel_act),
        .dat_s    (dat_s),
        .word_vld (word_vld),
        .word     (word)
    );

    synth_word_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (word_vld),
        .wr_word  (word),
        .ctl_q    (ctl_word),
        .freq0_q  (freq0_word),
        .freq1_q  (freq1_word),
        .phase0_q (phase0_word),
        .phase1_q (phase1_word)
    );
endmodule

// File: tb/synth_word_port_bench.sv
module synth_word_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1;
    logic ser_sel_n = 1'b1;
    logic ser_dat = 1'b0;
    logic [13:0] ctl_word;
    logic [27:0] freq0_word, freq1_word;
    logic [11:0] phase0_word, phase1_word;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [13:0] m_ctl;
    logic [27:0] m_f0, m_f1;
    logic [11:0] m_p0, m_p1;
    bit          m_high;
    bit          m_psel;
    logic [13:0] m_plow;

    always #10 clk = ~clk;

    synth_word_port u_synth_word_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_dat(ser_dat), .ctl_word(ctl_word), .freq0_word(freq0_word),
        .freq1_word(freq1_word), .phase0_word(phase0_word), .phase1_word(phase1_word)
    );

    task automatic model_reset();
        m_ctl = 14'h2100; m_f0 = '0; m_f1 = '0; m_p0 = '0; m_p1 = '0;
        m_high = 0; m_psel = 0; m_plow = '0;
    endtask

    task automatic model_word(input logic [15:0] w);
        logic sel;
        if (w[15:14] == 2'b00) begin
            m_ctl = w[13:0]; m_high = 0;
        end else if (w[15:14] == 2'b11) begin
            if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
            m_high = 0;
        end else begin
            sel = w[15];
            if (m_ctl[13]) begin
                if (m_high && m_psel == sel) begin
                    if (sel) m_f1 = {w[13:0], m_plow}; else m_f0 = {w[13:0], m_plow};
                    m_high = 0;
                end else begin
                    m_plow = w[13:0]; m_psel = sel; m_high = 1;
                end
            end else begin
                m_high = 0;
                if (m_ctl[12]) begin
                    if (sel) m_f1[27:14] = w[13:0]; else m_f0[27:14] = w[13:0];
                end else begin
                    if (sel) m_f1[13:0] = w[13:0]; else m_f0[13:0] = w[13:0];
                end
            end
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        @(negedge clk);
        ser_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        send_bits({16'h0, w}, 16);
        model_word(w);
    endtask

    task automatic check(input string req);
        total++;
        if (ctl_word !== m_ctl || freq0_word !== m_f0 || freq1_word !== m_f1 ||
            phase0_word !== m_p0 || phase1_word !== m_p1) begin
            bad++;
            $display("FAIL %s: got ctl=%h f0=%h f1=%h p0=%h p1=%h exp ctl=%h f0=%h f1=%h p0=%h p1=%h",
                req, ctl_word, freq0_word, freq1_word, phase0_word, phase1_word,
                m_ctl, m_f0, m_f1, m_p0, m_p1);
        end
    endtask

    function automatic logic [15:0] rand_word();
        logic [15:0] w = 16'($urandom);
        // keep two-write mode on most of the time
        if (w[15:14] == 2'b00 && ($urandom % 4) != 0) w[13] = 1'b1;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5c_9a07));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1");

        send_word(16'h2000); check("R4 control write");
        send_word(16'h3FFF); check("R4 all ones");
        send_word(16'h2000);

        // R6 two-write pair to frequency 0
        send_word(16'h4000 | 16'h1234); check("R6 low half pending");
        send_word(16'h4000 | 16'h0ABC); check("R6 pair committed");

        // R7 interrupted pair on frequency 1
        send_word(16'h8000 | 16'h0111); check("R7 low pending");
        send_word(16'hC000 | 16'h0055); check("R7 phase between halves");
        send_word(16'h8000 | 16'h0222); check("R7 restarted low");
        send_word(16'h4000 | 16'h0333); check("R7 other freq restarts");
        send_word(16'h4000 | 16'h0444); check("R7 pair on freq0");

        // R8 single-write halves
        send_word(16'h1000); check("R8 mode select high");
        send_word(16'h8000 | 16'h3A5A); check("R8 high half only");
        send_word(16'h0000);
        send_word(16'h8000 | 16'h15A5); check("R8 low half only");
        send_word(16'h2000);

        // R5 phase with bit 12 set
        send_word(16'hC000 | 16'h1ABC); check("R5 phase0 bit12 ignored");
        send_word(16'hE000 | 16'h1DEF); check("R5 phase1");

        // R2 short frame, R3 long frame
        send_bits(32'h0000_03FF, 10); check("R2 short frame dropped");
        send_bits(32'h0003_FFFF, 18); check("R3 long frame dropped");
        send_word(16'hC000 | 16'h0777); check("R2 frame after drops");

        // R9 serial clock toggles with select high
        for (int k = 0; k < 20; k++) begin
            ser_dat = k[0];
            ser_clk = ~ser_clk;
            repeat (4) @(negedge clk);
        end
        ser_clk = 1'b1;
        repeat (8) @(negedge clk);
        check("R9 idle clocks ignored");
        send_word(16'h0000 | 16'h2C3C); check("R9 R4 frame after idle clocks");

        // random traffic
        for (int n = 0; n < 300; n++) begin
            send_word(rand_word());
            check("R2 R6 R8 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule